// File: doc/BRIEF.md
# Flash Command Status Flag Controller

This block holds the status and error flags of an embedded flash command interface. Software loads a command in three steps. First it writes an aligned word into the array space. Next it writes the command register. Last it writes 1 to the buffer-ready flag, which launches the command. The block checks that the steps come in this order. It keeps one command running in the flash engine and can hold one more waiting behind it, and it reports when the buffer is free again and when all work has drained.

Steps taken out of order, an abandoned sequence, an illegal command code, a sector-erase abort and a stop request during activity all raise an access error. A write aimed at a protected region raises a protection error. A parity double fault raises its own flag and captures the failing address and parity bits. Each error flag is cleared by writing 1 to it. Three interrupt lines each combine a flag with an enable bit. The array timing is outside the block: the engine reports the end of each command with a one-cycle completion pulse.

Top module: `flash_cmd_status`

## Requirements
- R1: After reset, buf_empty and all_done are 1, prot_err, acc_err and dbl_fault are 0, the capture registers are 0 and the interrupt enables are 0.
- R2: A sequence made of an array write (arr_wr), then a command write (reg_sel=1, code in reg_wdata), then a status write (reg_sel=0) with bit 7 set clears buf_empty at the next edge. When no command is running, eng_go is then high for one cycle and presents the command code on eng_cmd and the word address on eng_addr.
- R3: An out-of-order step sets acc_err, launches nothing and returns the sequence to idle. Out-of-order steps are a command write with no array word before it, a second array write within a sequence, and a launch before the command write.
- R4: A status write with bit 7 at 0, made after the array word and before launch, aborts the sequence and sets acc_err. The same write made with no sequence open has no effect.
- R5: all_done is 1 exactly when buf_empty is 1 and no command is running. It stays 0 while a waiting command is handed to the engine, and status writes to bit 6 have no effect.
- R6: A launch while a command is running leaves buf_empty at 0 until eng_done. On that pulse eng_go hands over the waiting command, and buf_empty returns to 1 at the same edge.
- R7: An array write with prot_hit set, made while a sequence may start, sets prot_err. Writing 1 to status bit 5 clears prot_err, and writing 0 there leaves it set.
- R8: acc_err is set by an illegal command code (cmd_illegal with the command write), by erase_abort, and by stop_req while all_done is 0. stop_req while all_done is 1 has no effect. Writing 1 to status bit 4 clears acc_err.
- R9: While prot_err or acc_err is 1, array writes are ignored and no sequence can start.
- R10: dfault sets both dbl_fault and acc_err and discards a waiting command without launching it. Writing 1 to status bit 4 clears dbl_fault, and writing to status bit 3 has no effect.
- R11: cap_addr and cap_par take fault_addr and fault_par only on a fault that arrives while dbl_fault is 0. Later faults leave them unchanged.
- R12: Writing the enable register (reg_sel=2) loads bit 0 for buf_empty, bit 1 for all_done and bit 2 for dbl_fault. irq_buf, irq_done and irq_fault each equal their flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 command, 2 interrupt enable |
| reg_wdata | input | 8 | Register write data |
| arr_wr | input | 1 | Aligned word write into the array space |
| arr_addr | input | ADDR_W | Word address of that array write |
| prot_hit | input | 1 | The array write address lies in a protected region |
| cmd_illegal | input | 1 | The command code being written is not a legal command |
| erase_abort | input | 1 | A sector erase was cut short by an abort command |
| stop_req | input | 1 | Stop request from the processor |
| eng_done | input | 1 | The running command has finished (one-cycle pulse) |
| dfault | input | 1 | Parity double fault detected (one-cycle pulse) |
| fault_addr | input | ADDR_W | Address of the faulting word |
| fault_par | input | PAR_W | Stored parity bits of the faulting word |
| buf_empty | output | 1 | Command buffer ready for a new sequence |
| all_done | output | 1 | No command running or waiting |
| prot_err | output | 1 | Protection violation flag |
| acc_err | output | 1 | Access error flag |
| dbl_fault | output | 1 | Double fault flag |
| cap_addr | output | ADDR_W | Captured address of the first double fault |
| cap_par | output | PAR_W | Captured parity of the first double fault |
| eng_go | output | 1 | Hand the buffered command to the engine this cycle |
| eng_cmd | output | 8 | Command code handed over |
| eng_addr | output | ADDR_W | Word address handed over |
| irq_buf | output | 1 | Buffer-ready interrupt |
| irq_done | output | 1 | All-done interrupt |
| irq_fault | output | 1 | Double-fault interrupt |

## Verification
The command path is driven with a launch into an idle engine, which shows the one-cycle dip of the buffer flag, and with a launch behind a running command, which shows the waiting hold and that all_done stays low across the handover. A double fault is raised with a command waiting, which separates a discarded command from a launched one. The sequence rules are tried by taking each step out of order. A step ignored under an error is exposed through a later status write, which would itself raise an access error if the ignored write had opened a sequence. Repeated faults with and without a clear between them separate first-fault capture from overwriting.

// File: rtl/flash_cmd_status.sv
module flash_cmd_status #(
  parameter int ADDR_W = 16,
  parameter int PAR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              prot_hit,
  input  logic              cmd_illegal,
  input  logic              erase_abort,
  input  logic              stop_req,
  input  logic              eng_done,
  input  logic              dfault,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [PAR_W-1:0]  fault_par,
  output logic              buf_empty,
  output logic              all_done,
  output logic              prot_err,
  output logic              acc_err,
  output logic              dbl_fault,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [PAR_W-1:0]  cap_par,
  output logic              eng_go,
  output logic [7:0]        eng_cmd,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              irq_buf,
  output logic              irq_done,
  output logic              irq_fault
);

  typedef enum logic [1:0] {S_IDLE, S_WORD, S_CMD} seq_t;

  seq_t       seq;
  logic       active;
  logic [2:0] irq_en;

  logic wr_stat, wr_cmd, wr_en, err, arr_ok, seq_free;
  logic start, prot_set, cmd_ok, launch, viol, acc_set;

  assign wr_stat  = reg_wr && reg_sel == 2'd0;
  assign wr_cmd   = reg_wr && reg_sel == 2'd1;
  assign wr_en    = reg_wr && reg_sel == 2'd2;
  assign err      = prot_err | acc_err;
  assign arr_ok   = arr_wr && !err;
  assign seq_free = seq == S_IDLE && buf_empty;
  assign start    = arr_ok && seq_free && !prot_hit;
  assign prot_set = arr_ok && seq_free && prot_hit;
  assign cmd_ok   = wr_cmd && seq == S_WORD && !cmd_illegal;
  assign launch   = wr_stat && seq == S_CMD && reg_wdata[7] && !err;

  assign viol = (arr_ok && !seq_free)
              | (wr_cmd && !cmd_ok)
              | (wr_stat && seq == S_WORD)
              | (wr_stat && seq == S_CMD && !reg_wdata[7]);

  assign acc_set = viol | (stop_req && !all_done) | erase_abort | dfault;

  assign eng_go    = !buf_empty && (!active || eng_done) && !dfault;
  assign all_done  = buf_empty && !active;
  assign irq_buf   = buf_empty & irq_en[0];
  assign irq_done  = all_done  & irq_en[1];
  assign irq_fault = dbl_fault & irq_en[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= S_IDLE;
    end else if (acc_set || prot_set) begin
      seq <= S_IDLE;
    end else if (start) begin
      seq <= S_WORD;
    end else if (cmd_ok) begin
      seq <= S_CMD;
    end else if (launch) begin
      seq <= S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_empty <= 1'b1;
      active    <= 1'b0;
    end else begin
      if (launch)                buf_empty <= 1'b0;
      else if (eng_go || dfault) buf_empty <= 1'b1;
      if (eng_go)                active <= 1'b1;
      else if (eng_done)         active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_err  <= 1'b0;
      acc_err   <= 1'b0;
      dbl_fault <= 1'b0;
    end else begin
      if (prot_set)                        prot_err  <= 1'b1;
      else if (wr_stat && reg_wdata[5])    prot_err  <= 1'b0;
      if (acc_set)                         acc_err   <= 1'b1;
      else if (wr_stat && reg_wdata[4])    acc_err   <= 1'b0;
      if (dfault)                          dbl_fault <= 1'b1;
      else if (wr_stat && reg_wdata[4])    dbl_fault <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_par  <= '0;
      eng_cmd  <= '0;
      eng_addr <= '0;
      irq_en   <= '0;
    end else begin
      if (dfault && !dbl_fault) begin
        cap_addr <= fault_addr;
        cap_par  <= fault_par;
      end
      if (cmd_ok) eng_cmd  <= reg_wdata;
      if (start)  eng_addr <= arr_addr;
      if (wr_en)  irq_en   <= reg_wdata[2:0];
    end
  end

  p_fault_sets_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_fault |-> acc_err);

  p_first_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_fault && $past(dbl_fault)) |-> ($stable(cap_addr) && $stable(cap_par)));

  p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_done) |-> ($past(eng_done) || $past(dfault)));

  p_handover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> (buf_empty && !all_done));

  p_irq_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fault |-> dbl_fault);

  p_launch_drops_buf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !buf_empty);

endmodule

// File: tb/flash_cmd_status_tb_top.sv
`timescale 1ns/100ps
module flash_cmd_status_tb_top;
  localparam int AW = 16;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, arr_wr = 0, prot_hit = 0, cmd_illegal = 0;
  logic erase_abort = 0, stop_req = 0, eng_done = 0, dfault = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [AW-1:0] arr_addr = 0, fault_addr = 0;
  logic [PW-1:0] fault_par = 0;
  logic buf_empty, all_done, prot_err, acc_err, dbl_fault, eng_go;
  logic irq_buf, irq_done, irq_fault;
  logic [AW-1:0] cap_addr, eng_addr;
  logic [PW-1:0] cap_par;
  logic [7:0] eng_cmd;

  always #2.5 clk = ~clk;

  flash_cmd_status #(.ADDR_W(AW), .PAR_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .arr_wr(arr_wr), .arr_addr(arr_addr),
    .prot_hit(prot_hit), .cmd_illegal(cmd_illegal), .erase_abort(erase_abort),
    .stop_req(stop_req), .eng_done(eng_done), .dfault(dfault),
    .fault_addr(fault_addr), .fault_par(fault_par), .buf_empty(buf_empty),
    .all_done(all_done), .prot_err(prot_err), .acc_err(acc_err),
    .dbl_fault(dbl_fault), .cap_addr(cap_addr), .cap_par(cap_par),
    .eng_go(eng_go), .eng_cmd(eng_cmd), .eng_addr(eng_addr),
    .irq_buf(irq_buf), .irq_done(irq_done), .irq_fault(irq_fault));

  int nchk = 0, nfail = 0, go_cnt = 0;
  logic [7:0] last_go_cmd = 0;

  // reference model state: 0 no sequence, 1 word taken, 2 command taken
  int m_stage = 0;
  int m_waiting = 0;
  int m_running = 0;
  int m_pe = 0, m_ae = 0, m_df = 0;
  int m_cmd = 0, m_addr = 0, m_ca = 0, m_cp = 0, m_en = 0;

  function automatic int m_go();
    return (m_waiting != 0 && (m_running == 0 || eng_done) && !dfault) ? 1 : 0;
  endfunction

  function automatic int m_alldone();
    return (m_waiting == 0 && m_running == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_waiting = 0; m_running = 0;
      m_pe = 0; m_ae = 0; m_df = 0;
      m_cmd = 0; m_addr = 0; m_ca = 0; m_cp = 0; m_en = 0;
    end else begin
      automatic int blocked = (m_pe != 0 || m_ae != 0) ? 1 : 0;
      automatic int go = m_go();
      automatic int bad = 0, pset = 0, fire = 0;
      automatic int nstage = m_stage;
      automatic int wasdone = m_alldone();
      if (arr_wr && blocked == 0) begin
        if (m_stage != 0 || m_waiting != 0) bad = 1;
        else if (prot_hit) pset = 1;
        else begin nstage = 1; m_addr = arr_addr; end
      end
      if (reg_wr && reg_sel == 1) begin
        if (m_stage == 1 && !cmd_illegal) begin nstage = 2; m_cmd = reg_wdata; end
        else bad = 1;
      end
      if (reg_wr && reg_sel == 0) begin
        if (m_stage == 1) bad = 1;
        else if (m_stage == 2) begin
          if (!reg_wdata[7]) bad = 1;
          else if (blocked == 0) begin fire = 1; nstage = 0; end
        end
      end
      if (reg_wr && reg_sel == 2) m_en = reg_wdata[2:0];
      if (dfault && m_df == 0) begin m_ca = fault_addr; m_cp = fault_par; end
      if (bad || (stop_req && wasdone == 0) || erase_abort || dfault) begin
        m_ae = 1; nstage = 0;
      end else if (reg_wr && reg_sel == 0 && reg_wdata[4]) m_ae = 0;
      if (pset) begin m_pe = 1; nstage = 0; end
      else if (reg_wr && reg_sel == 0 && reg_wdata[5]) m_pe = 0;
      if (dfault) m_df = 1;
      else if (reg_wr && reg_sel == 0 && reg_wdata[4]) m_df = 0;
      if (fire) m_waiting = 1;
      else if (go || dfault) m_waiting = 0;
      if (go) m_running = 1;
      else if (eng_done) m_running = 0;
      m_stage = nstage;
    end
  end

  task automatic cmp(input string tag, input string nm, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (eng_go) begin go_cnt++; last_go_cmd = eng_cmd; end
      cmp("R6", "buf_empty", buf_empty, m_waiting == 0);
      cmp("R5", "all_done", all_done, m_alldone());
      cmp("R7", "prot_err", prot_err, m_pe);
      cmp("R8", "acc_err", acc_err, m_ae);
      cmp("R10", "dbl_fault", dbl_fault, m_df);
      cmp("R11", "cap_addr", cap_addr, m_ca);
      cmp("R11", "cap_par", cap_par, m_cp);
      cmp("R2", "eng_go", eng_go, m_go());
      cmp("R2", "eng_cmd", eng_cmd, m_cmd);
      cmp("R2", "eng_addr", eng_addr, m_addr);
      cmp("R12", "irq_buf", irq_buf, (m_waiting == 0) && m_en[0]);
      cmp("R12", "irq_done", irq_done, m_alldone() && m_en[1]);
      cmp("R12", "irq_fault", irq_fault, m_df && m_en[2]);
    end
  end

  task automatic clr();
    reg_wr = 0; arr_wr = 0; prot_hit = 0; cmd_illegal = 0;
    erase_abort = 0; stop_req = 0; eng_done = 0; dfault = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [7:0] d, input logic ill = 0);
    @(negedge clk); #1;
    reg_wr = 1; reg_sel = sel; reg_wdata = d; cmd_illegal = ill;
    @(negedge clk); #1; clr();
  endtask

  task automatic warr(input logic [AW-1:0] a, input logic p);
    @(negedge clk); #1;
    arr_wr = 1; arr_addr = a; prot_hit = p;
    @(negedge clk); #1; clr();
  endtask

  task automatic pulse(input int which);
    @(negedge clk); #1;
    case (which)
      0: eng_done = 1;
      1: erase_abort = 1;
      default: stop_req = 1;
    endcase
    @(negedge clk); #1; clr();
  endtask

  task automatic fault(input logic [AW-1:0] a, input logic [PW-1:0] p);
    @(negedge clk); #1;
    dfault = 1; fault_addr = a; fault_par = p;
    @(negedge clk); #1; clr();
  endtask

  task automatic launch(input logic [AW-1:0] a, input logic [7:0] c);
    warr(a, 0);
    wreg(1, c);
    wreg(0, 8'h80);
  endtask

  bit finished = 0;

  initial begin
    #1_000_000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    cmp("R1", "buf_empty", buf_empty, 1);
    cmp("R1", "all_done", all_done, 1);
    cmp("R1", "errors", {prot_err, acc_err, dbl_fault}, 0);
    cmp("R1", "cap_addr", cap_addr, 0);
    cmp("R1", "irqs", {irq_buf, irq_done, irq_fault}, 0);

    wreg(2, 8'h07);
    cmp("R12", "irq_buf/done", {irq_buf, irq_done, irq_fault}, 3'b110);

    // R2 launch into idle engine
    launch(16'h0100, 8'h20);
    cmp("R2", "buf_empty after launch", buf_empty, 0);
    cmp("R5", "all_done after launch", all_done, 0);
    cmp("R2", "eng_go", eng_go, 1);
    cmp("R2", "eng_cmd", eng_cmd, 8'h20);
    cmp("R2", "eng_addr", eng_addr, 16'h0100);
    idle(1);
    cmp("R2", "go count", go_cnt, 1);
    cmp("R2", "buf_empty back", buf_empty, 1);
    cmp("R5", "all_done while running", all_done, 0);
    pulse(0);
    cmp("R5", "all_done after finish", all_done, 1);

    // R6 pending command behind a running one
    launch(16'h0200, 8'h40);
    idle(1);
    launch(16'h0300, 8'h41);
    idle(3);
    cmp("R6", "buf_empty held", buf_empty, 0);
    cmp("R6", "go count held", go_cnt, 2);
    wreg(0, 8'h40);
    cmp("R5", "bit6 write ignored", all_done, 0);
    cmp("R4", "bit7=0 outside sequence", acc_err, 0);
    pulse(0);
    cmp("R6", "handover go", go_cnt, 3);
    cmp("R6", "handover cmd", last_go_cmd, 8'h41);
    cmp("R6", "buf_empty after handover", buf_empty, 1);
    cmp("R5", "no all_done on handover", all_done, 0);
    pulse(0);
    cmp("R5", "all_done final", all_done, 1);

    // R4 abort
    warr(16'h0400, 0);
    wreg(0, 8'h00);
    cmp("R4", "abort sets acc", acc_err, 1);
    wreg(0, 8'h10);
    cmp("R8", "acc w1c", acc_err, 0);

    // R3 order violations
    wreg(1, 8'h20);
    cmp("R3", "cmd without word", acc_err, 1);
    wreg(0, 8'h10);
    warr(16'h0500, 0);
    warr(16'h0502, 0);
    cmp("R3", "double word", acc_err, 1);
    wreg(0, 8'h10);
    warr(16'h0600, 0);
    wreg(0, 8'h80);
    cmp("R3", "early launch", acc_err, 1);
    cmp("R3", "early launch no go", go_cnt, 3);
    wreg(0, 8'h10);

    // R8 sources
    warr(16'h0700, 0);
    wreg(1, 8'h55, 1);
    cmp("R8", "illegal cmd", acc_err, 1);
    wreg(0, 8'h10);
    pulse(1);
    cmp("R8", "erase abort", acc_err, 1);
    wreg(0, 8'h10);
    pulse(2);
    cmp("R8", "stop while idle", acc_err, 0);
    launch(16'h0800, 8'h22);
    idle(1);
    pulse(2);
    cmp("R8", "stop while running", acc_err, 1);
    pulse(0);
    wreg(0, 8'h10);

    // R7 / R9 protection
    warr(16'h0900, 1);
    cmp("R7", "prot set", prot_err, 1);
    wreg(0, 8'h00);
    cmp("R7", "prot write0", prot_err, 1);
    warr(16'h0A00, 0);
    wreg(0, 8'h20);
    cmp("R7", "prot w1c", prot_err, 0);
    cmp("R9", "word ignored under error", acc_err, 0);
    wreg(1, 8'h30);
    cmp("R9", "no sequence open", acc_err, 1);
    cmp("R9", "no launch", go_cnt, 4);
    wreg(0, 8'h10);

    // R10 / R11 double faults
    fault(16'h0ABC, 8'h5A);
    cmp("R10", "dbl set", dbl_fault, 1);
    cmp("R10", "acc with dbl", acc_err, 1);
    cmp("R11", "cap addr", cap_addr, 16'h0ABC);
    cmp("R11", "cap par", cap_par, 8'h5A);
    cmp("R12", "irq_fault", irq_fault, 1);
    wreg(0, 8'h08);
    cmp("R10", "bit3 write ignored", dbl_fault, 1);
    fault(16'h0DEF, 8'h33);
    cmp("R11", "keep first addr", cap_addr, 16'h0ABC);
    cmp("R11", "keep first par", cap_par, 8'h5A);
    wreg(0, 8'h10);
    cmp("R10", "dbl cleared via bit4", dbl_fault, 0);
    cmp("R10", "acc cleared", acc_err, 0);
    fault(16'h0123, 8'h0F);
    cmp("R11", "new capture", cap_addr, 16'h0123);
    wreg(0, 8'h10);

    // R10 waiting command discarded
    launch(16'h0B00, 8'h60);
    idle(1);
    launch(16'h0C00, 8'h61);
    fault(16'h0777, 8'h01);
    cmp("R10", "pending dropped", buf_empty, 1);
    cmp("R10", "still running", all_done, 0);
    pulse(0);
    cmp("R10", "no launch of dropped", go_cnt, 5);
    cmp("R10", "all_done after drop", all_done, 1);
    wreg(0, 8'h10);

    wreg(2, 8'h00);
    cmp("R12", "irqs disabled", {irq_buf, irq_done, irq_fault}, 0);
    idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule